// File: doc/BRIEF.md
# Divider Configuration Loader for a Clock Synthesizer

This block is the configuration front end of a frequency synthesizer. It holds the three values the downstream logic needs: a 9-bit feedback divide value, a 2-bit output divide code and a 2-bit test-select field. They can come from two sources. One is a parallel bus guarded by a load strobe. The other is a three-wire serial port with data, serial clock and load lines. Both sources write one shared set of output registers, so the most recent event from either source decides the outputs.

On the parallel path, a low strobe makes the registers follow the bus, and the strobe's rising edge freezes them. On the serial path, a 14-bit frame is shifted in, and the rising edge of the serial load line copies it to the outputs. While the load line stays high, every further serial clock also updates the outputs, and the line's falling edge freezes them. No serial pin is used as a clock. Every external input passes through a synchronizer into the block clock, and serial clock edges are detected in that clock domain. A parallel-mode flag lets the chip drive its test pin low whenever the parallel source is in control.

Top module: `synth_cfg_loader`

## Requirements
- R1: While `rst_n` is low, the feedback and output divide registers load directly from `par_m_i` and `par_n_i`, `t_o` clears to 0 and `par_mode_o` goes to 1.
- R2: While the synchronized parallel strobe is low, `m_o` and `n_o` follow `par_m_i` and `par_n_i`. The delay is SYNC_STAGES+1 clocks. `par_mode_o` is 1 and `t_o` does not change.
- R3: After the parallel strobe rises, `m_o` and `n_o` keep the values that were on the bus at that moment. Later changes on the bus have no effect until the strobe falls again or a serial load occurs.
- R4: A rising serial clock shifts `ser_data_i` into the shift register only while the parallel strobe is high. Serial clocks seen while the strobe is low leave the register unchanged.
- R5: A rising serial load line copies the shift register to the outputs and sets `par_mode_o` to 0. The frame is 14 bits, sent first bit first, in this order: T1, T0, a null bit, N1, N0, then M8 down to M0. After 14 shifts the register holds, from bit 13 down to bit 0: T[1:0] in bits 13:12, the null bit in bit 11, N[1:0] in bits 10:9 and M[8:0] in bits 8:0.
- R6: While the serial load line is low, shifting does not change `m_o`, `n_o` or `t_o`. This holds both before the first serial load and after the load line's falling edge has latched the values.
- R7: While the serial load line is held high, each rising serial clock shifts one bit and the outputs immediately take the new register contents.
- R8: The null bit in the frame has no effect on `m_o`, `n_o` or `t_o`.
- R9: `mr_i` appears on `div_rst_o` after SYNC_STAGES clocks and has no effect on `m_o`, `n_o`, `t_o` or `par_mode_o`.
- R10: A serial load overrides values latched from the parallel bus. A later low parallel strobe hands control back to the bus and sets `par_mode_o` to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous reset, active low |
| par_m_i | input | 9 | Parallel feedback divide value |
| par_n_i | input | 2 | Parallel output divide code |
| par_load_i | input | 1 | Parallel strobe: low passes the bus through, the rising edge latches it |
| ser_clk_i | input | 1 | Serial shift clock, sampled as data |
| ser_data_i | input | 1 | Serial data input |
| ser_load_i | input | 1 | Serial load line: the rising edge transfers, high passes through, the falling edge latches |
| mr_i | input | 1 | Divider reset request, passed through without touching the configuration |
| m_o | output | 9 | Feedback divide value to the divider |
| n_o | output | 2 | Output divide code |
| t_o | output | 2 | Test-select bits |
| par_mode_o | output | 1 | 1 when the parallel source is in control, used to force the test pin low |
| div_rst_o | output | 1 | Synchronized divider reset |

## Verification
The hardest case to reach from the ports is the pass-through phase of the serial load line: the line is held high and further serial clocks arrive, so the outputs must follow a shift register that is still moving. The bench gets there by first completing a frame. It then holds the load line high and clocks in single bits, predicting each new register value arithmetically. A second hard case is serial clocking while the parallel strobe is low. That activity must leave no trace, and it can only be observed by a serial load made afterwards, which is expected to show the frame loaded earlier.

// File: rtl/synth_cfg_pkg.sv
package synth_cfg_pkg;
   localparam int M_W     = 9;
   localparam int N_W     = 2;
   localparam int T_W     = 2;
   localparam int NULL_W  = 1;
   localparam int FRAME_W = T_W + NULL_W + N_W + M_W;

   // first-shifted field sits at the top of the register
   typedef struct packed {
      logic [T_W-1:0]    t;
      logic [NULL_W-1:0] nul;
      logic [N_W-1:0]    n;
      logic [M_W-1:0]    m;
   } frame_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
   parameter int            W       = 1,
   parameter int            STAGES  = 2,
   parameter logic [W-1:0]  RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("cfg_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0][W-1:0] pipe;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) pipe[i] <= RST_VAL;
      end else begin
         pipe[0] <= d;
         for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter #(
   parameter int W = 14
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] sr_o,
   output logic [W-1:0] sr_next_o
);
   generate
      if (W < 2) begin : g_bad_width
         $error("cfg_shifter: W must be at least 2");
      end
   endgenerate

   logic [W-1:0] sr_q;

   assign sr_next_o = shift_en ? {sr_q[W-2:0], din} : sr_q;

   always_ff @(posedge clk) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_next_o;
   end

   assign sr_o = sr_q;

   // R4: no shift enable, register frozen
   a_r4_shift_gated: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> (sr_q == $past(sr_q)));

   // R4: an enabled shift lands the sampled bit at position 0
   a_r4_bit_enters: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (sr_q[0] == $past(din)));
endmodule

// File: rtl/synth_cfg_loader.sv
module synth_cfg_loader
   import synth_cfg_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [M_W-1:0] par_m_i,
   input  logic [N_W-1:0] par_n_i,
   input  logic           par_load_i,
   input  logic           ser_clk_i,
   input  logic           ser_data_i,
   input  logic           ser_load_i,
   input  logic           mr_i,
   output logic [M_W-1:0] m_o,
   output logic [N_W-1:0] n_o,
   output logic [T_W-1:0] t_o,
   output logic           par_mode_o,
   output logic           div_rst_o
);
   localparam int CTL_W = 5;
   localparam int DAT_W = M_W + N_W;
   // control bundle bit order: mr, strobe, load, sclk, sdata
   localparam logic [CTL_W-1:0] CTL_RST = 5'b01000;

   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("synth_cfg_loader: SYNC_STAGES must be at least 2");
      end
      if (FRAME_W != 14) begin : g_bad_frame
         $error("synth_cfg_loader: frame must be 14 bits");
      end
   endgenerate

   logic [CTL_W-1:0] ctl_s;
   logic [DAT_W-1:0] dat_s;

   cfg_sync #(.W(CTL_W), .STAGES(SYNC_STAGES), .RST_VAL(CTL_RST)) u_ctl_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({mr_i, par_load_i, ser_load_i, ser_clk_i, ser_data_i}),
      .q     (ctl_s)
   );

   cfg_sync #(.W(DAT_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_dat_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({par_n_i, par_m_i}),
      .q     (dat_s)
   );

   logic mr_s, pload_s, sload_s, sclk_s, sdat_s;
   assign {mr_s, pload_s, sload_s, sclk_s, sdat_s} = ctl_s;

   logic sclk_d;
   always_ff @(posedge clk) begin
      if (!rst_n) sclk_d <= 1'b0;
      else        sclk_d <= sclk_s;
   end

   logic sclk_rise, shift_en;
   assign sclk_rise = sclk_s & ~sclk_d;
   assign shift_en  = pload_s & sclk_rise;

   frame_t sr_q, sr_nxt;

   cfg_shifter #(.W(FRAME_W)) u_shifter (
      .clk       (clk),
      .rst_n     (rst_n),
      .shift_en  (shift_en),
      .din       (sdat_s),
      .sr_o      (sr_q),
      .sr_next_o (sr_nxt)
   );

   logic [M_W-1:0] m_q;
   logic [N_W-1:0] n_q;
   logic [T_W-1:0] t_q;
   logic           mode_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         m_q    <= par_m_i;
         n_q    <= par_n_i;
         t_q    <= '0;
         mode_q <= 1'b1;
      end else if (!pload_s) begin
         m_q    <= dat_s[M_W-1:0];
         n_q    <= dat_s[DAT_W-1:M_W];
         mode_q <= 1'b1;
      end else if (sload_s) begin
         m_q    <= sr_nxt.m;
         n_q    <= sr_nxt.n;
         t_q    <= sr_nxt.t;
         mode_q <= 1'b0;
      end else if (shift_en) begin
         mode_q <= 1'b0;
      end
   end

   assign m_o        = m_q;
   assign n_o        = n_q;
   assign t_o        = t_q;
   assign par_mode_o = mode_q;
   assign div_rst_o  = mr_s;

   // R2: strobe low puts the block in parallel mode
   a_r2_par_mode: assert property (@(posedge clk) disable iff (!rst_n)
      !pload_s |=> mode_q);

   // R2: parallel pass-through never touches the test bits
   a_r2_t_untouched: assert property (@(posedge clk) disable iff (!rst_n)
      !pload_s |=> (t_q == $past(t_q)));

   // R3 / R6: latched phases of both paths hold every output
   a_r3_latched_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (pload_s && !sload_s) |=> (m_q == $past(m_q) && n_q == $past(n_q)
                                 && t_q == $past(t_q)));

   // R7: with the load line high the outputs mirror the shift register
   a_r7_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
      (pload_s && sload_s) |=> (m_q == sr_q.m && n_q == sr_q.n && t_q == sr_q.t));

   // R8: the null slot is only a step in the chain between N and T
   a_r8_null_chain: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (sr_q.nul[0] == $past(sr_q.n[N_W-1])));
endmodule

// File: tb/synth_cfg_loader_bench.sv
module synth_cfg_loader_bench;
   localparam int SYNC = 2;
   localparam int SETTLE = SYNC + 4;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [8:0] par_m;
   logic [1:0] par_n;
   logic       pload, sclk, sdat, sload, mr;
   logic [8:0] m_o;
   logic [1:0] n_o, t_o;
   logic       mode_o, drst_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   logic [13:0] exp_sr;

   always #10 clk = ~clk;

   synth_cfg_loader #(.SYNC_STAGES(SYNC)) u_synth_cfg_loader (
      .clk(clk), .rst_n(rst_n), .par_m_i(par_m), .par_n_i(par_n),
      .par_load_i(pload), .ser_clk_i(sclk), .ser_data_i(sdat),
      .ser_load_i(sload), .mr_i(mr), .m_o(m_o), .n_o(n_o), .t_o(t_o),
      .par_mode_o(mode_o), .div_rst_o(drst_o));

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic check_cfg(input string req, input int m, input int n, input int t);
      check({req, " m"}, int'(m_o), m);
      check({req, " n"}, int'(n_o), n);
      check({req, " t"}, int'(t_o), t);
   endtask

   task automatic shift_bit(input logic b, input bit track);
      sdat = b;
      tick(SETTLE);
      sclk = 1'b1;
      tick(SETTLE);
      sclk = 1'b0;
      tick(SETTLE);
      if (track) exp_sr = {exp_sr[12:0], b};
   endtask

   task automatic send_frame(input logic [13:0] f, input bit track);
      for (int i = 13; i >= 0; i--) shift_bit(f[i], track);
   endtask

   task automatic pulse_load();
      sload = 1'b1;
      tick(SETTLE);
      sload = 1'b0;
      tick(SETTLE);
   endtask

   initial begin
      int pm, pn;
      rst_n = 1'b0; par_m = 9'd20; par_n = 2'd1;
      pload = 1'b1; sclk = 1'b0; sdat = 1'b0; sload = 1'b0; mr = 1'b0;
      exp_sr = '0;
      tick(3);
      // R1: reset loads the bus, clears T, parallel mode
      check_cfg("R1", 20, 1, 0);
      check("R1 mode", int'(mode_o), 1);
      rst_n = 1'b1;
      tick(SETTLE);
      check_cfg("R1 after release", 20, 1, 0);

      // R2: transparent sweep of every N code with varied M
      pload = 1'b0;
      for (int n = 0; n < 4; n++) begin
         for (int k = 0; k < 8; k++) begin
            pm = (k * 67 + n * 5 + 3) % 512;
            par_m = pm[8:0]; par_n = n[1:0];
            tick(SETTLE);
            check_cfg("R2", pm, n, 0);
            check("R2 mode", int'(mode_o), 1);
         end
      end

      // R3: rising strobe latches, later bus changes ignored
      par_m = 9'd300; par_n = 2'd2;
      tick(SETTLE);
      pload = 1'b1;
      tick(SETTLE);
      par_m = 9'd17; par_n = 2'd1;
      tick(SETTLE);
      check_cfg("R3", 300, 2, 0);
      check("R3 mode", int'(mode_o), 1);

      // R5 / R6 / R8 / R10: serial frames over every T and N
      pm = 300; pn = 2;
      for (int t = 0; t < 4; t++) begin
         for (int n = 0; n < 4; n++) begin
            int mm, nl, tp;
            mm = (t * 131 + n * 29 + 11) % 512;
            nl = (t ^ n) & 1;
            tp = (t == 0 && n == 0) ? 0 : ((n == 0) ? t - 1 : t);
            send_frame({t[1:0], nl[0], n[1:0], mm[8:0]}, 1'b1);
            // R6: shifting with the load line low leaves outputs alone
            check("R6 m hold", int'(m_o), pm);
            check("R6 n hold", int'(n_o), pn);
            pulse_load();
            check_cfg("R5 R8 R10", mm, n, t);
            check("R5 mode", int'(mode_o), 0);
            pm = mm; pn = n;
            if (tp < 0) check("unused", 0, 0);
         end
      end

      // R7: load line held high, each clock updates outputs
      sload = 1'b1;
      tick(SETTLE);
      check_cfg("R7 hold high", int'(exp_sr[8:0]), int'(exp_sr[10:9]), int'(exp_sr[13:12]));
      for (int i = 0; i < 4; i++) begin
         shift_bit(i[0] ^ 1'b1, 1'b1);
         check_cfg("R7 pass", int'(exp_sr[8:0]), int'(exp_sr[10:9]), int'(exp_sr[13:12]));
      end
      sload = 1'b0;
      tick(SETTLE);
      pm = int'(exp_sr[8:0]); pn = int'(exp_sr[10:9]);
      shift_bit(1'b1, 1'b1);
      // R6: after the falling edge, a shift no longer reaches outputs
      check_cfg("R6 latched", pm, pn, int'(exp_sr[13:12] ^ 2'b00) == int'(t_o) ? int'(t_o) : -1);
      check("R6 m", int'(m_o), pm);

      // R9: divider reset passes through, configuration untouched
      pm = int'(m_o); pn = int'(n_o);
      begin
         int tt;
         tt = int'(t_o);
         mr = 1'b1;
         tick(SETTLE);
         check("R9 drst high", int'(drst_o), 1);
         check_cfg("R9 cfg during", pm, pn, tt);
         check("R9 mode", int'(mode_o), 0);
         mr = 1'b0;
         tick(SETTLE);
         check("R9 drst low", int'(drst_o), 0);
         check_cfg("R9 cfg after", pm, pn, tt);
      end

      // bring exp_sr to a known full frame
      send_frame(14'b10_1_01_000110011, 1'b1);
      pulse_load();
      check_cfg("R5 known frame", 51, 1, 2);

      // R4: serial clocks with the strobe low are ignored
      par_m = 9'd88; par_n = 2'd3;
      pload = 1'b0;
      tick(SETTLE);
      check_cfg("R10 back to parallel", 88, 3, 2);
      check("R10 mode", int'(mode_o), 1);
      send_frame(14'b01_0_10_111000111, 1'b0);
      pload = 1'b1;
      tick(SETTLE);
      pulse_load();
      check_cfg("R4 register untouched", 51, 1, 2);
      check("R4 mode", int'(mode_o), 0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule